// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the software-visible state of a single DMA channel. A 16-byte register window exposes four 32-bit words: control/status, current transfer address, byte count, and an upper-address word. A processor writes the window through a simple write strobe and reads it combinationally. The block drives the channel interrupt and a one-cycle reset strobe toward the attached peripheral. It also tells the data mover which way the transfer runs.

A separate data mover reports each completed burst with a strobe and a byte length. The block advances the current address by that length and flags the interrupt. A level interrupt from the peripheral also sets and clears the pending flag, on its rising and falling edges. On the data path, the block forms the outgoing memory address by ORing the mover's request address with the upper-address word. It can exchange the two bytes of every 16-bit halfword in both directions.

Top module: `dmacr_chan`

## Requirements
- R1: After synchronous reset, the control word reads 0xA0000000 and the address, count and upper words read 0.
- R2: The word index is byte-address bits [3:2], so only the offset modulo 16 matters. Index 0 is control, 1 is address, 2 is count and 3 is upper.
- R3: Control bits [31:28] always read 0xA and ignore writes. Bit 0 is the interrupt-pending status and ignores writes. All other control bits store the written value, subject to R6.
- R4: `irq` is high exactly when pending (bit 0) and interrupt enable (bit 4) are both 1. A control write with bit 4 clear forces `irq` low in the same cycle as the write.
- R5: A control write with bit 7 set drives `periph_rst` high for exactly the following cycle.
- R6: A control write with bit 6 (drain) set and bit 7 clear stores bit 6 as 0. With bit 7 set, bit 6 is stored as written.
- R7: Any write to the address word also sets control bit 26 (address loaded).
- R8: A `xfer_done` strobe adds `xfer_len` to the address word and sets pending. In the same cycle, a register write to the address word takes priority over the addition.
- R9: A rising edge of `periph_irq` sets pending and a falling edge clears it. A `xfer_done` strobe in the same cycle as a falling edge leaves pending set.
- R10: `mem_addr` equals `req_addr` ORed with the upper word.
- R11: With `swap_en` high, both data paths exchange the two bytes inside each 16-bit halfword. With `swap_en` low, they pass data unchanged.
- R12: Reading has no side effects. `dir_to_mem` follows control bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Byte offset into the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| xfer_done | input | 1 | Data mover burst-complete strobe |
| xfer_len | input | LEN_W | Bytes moved by the reported burst |
| periph_irq | input | 1 | Level interrupt from the peripheral |
| irq | output | 1 | Channel interrupt |
| periph_rst | output | 1 | One-cycle reset strobe to the peripheral |
| dir_to_mem | output | 1 | Transfer direction, 1 = write memory |
| req_addr | input | 32 | Address requested by the data mover |
| mem_addr | output | 32 | Request address merged with the upper word |
| swap_en | input | 1 | Enable halfword byte exchange |
| mem_rd_data | input | DATA_W | Data read from memory |
| dev_rd_data | output | DATA_W | Read data toward the peripheral |
| dev_wr_data | input | DATA_W | Data from the peripheral to memory |
| mem_wr_data | output | DATA_W | Write data toward memory |

## Verification
Directed sequences drive the control word with reset and drain set together and apart. This separates the R5 and R6 behaviours and shows the read-only version and pending bits. Burst reports are driven alone, together with an address write, and together with a falling peripheral interrupt. These cases tell apart the address-write priority and the set-beats-clear rule for pending. A long random phase then mixes writes at unaligned offsets, bursts, interrupt toggles and swap settings. A behavioural model compares every output on every cycle in this phase, so wrong index decoding or a wrong update priority shows up as a mismatch.

// File: rtl/dmacr_pkg.sv
package dmacr_pkg;

    typedef enum logic [1:0] {
        IDX_CTRL  = 2'd0,
        IDX_ADDR  = 2'd1,
        IDX_COUNT = 2'd2,
        IDX_UPPER = 2'd3
    } reg_idx_e;

    localparam logic [3:0] VERSION_NIB = 4'hA;

    localparam int B_PEND   = 0;
    localparam int B_IEN    = 4;
    localparam int B_DRAIN  = 6;
    localparam int B_PRST   = 7;
    localparam int B_TOMEM  = 8;
    localparam int B_LOADED = 26;

    typedef struct packed {
        logic        we;
        reg_idx_e    idx;
        logic [31:0] data;
    } reg_wr_t;

    // value kept in the control word for a given written value
    function automatic logic [31:0] ctrl_store(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        if (!v[B_PRST] && v[B_DRAIN])
            r[B_DRAIN] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/dmacr_ctrl.sv
module dmacr_ctrl
    import dmacr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  reg_wr_t     wr,
    input  logic        xfer_done,
    input  logic        periph_irq,
    output logic [31:0] ctrl_o,
    output logic        irq_o,
    output logic        periph_rst_o
);

    logic [27:1] body_q;
    logic        pend_q;
    logic        pirq_q;
    logic        rstp_q;
    logic        ctrl_we;
    logic [31:0] stored;
    logic        rise, fall;

    assign ctrl_we = wr.we && (wr.idx == IDX_CTRL);
    assign stored  = ctrl_store(wr.data);
    assign rise    = periph_irq && !pirq_q;
    assign fall    = !periph_irq && pirq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            body_q <= '0;
            pend_q <= 1'b0;
            pirq_q <= 1'b0;
            rstp_q <= 1'b0;
        end else begin
            pirq_q <= periph_irq;
            rstp_q <= ctrl_we && wr.data[B_PRST];
            if (ctrl_we)
                body_q <= stored[27:1];
            else if (wr.we && wr.idx == IDX_ADDR)
                body_q[B_LOADED] <= 1'b1;
            if (xfer_done || rise)
                pend_q <= 1'b1;
            else if (fall)
                pend_q <= 1'b0;
        end
    end

    assign ctrl_o       = {VERSION_NIB, body_q, pend_q};
    assign irq_o        = pend_q && body_q[B_IEN] && !(ctrl_we && !wr.data[B_IEN]);
    assign periph_rst_o = rstp_q;

endmodule

// File: rtl/dmacr_addr.sv
module dmacr_addr
    import dmacr_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  reg_wr_t          wr,
    input  logic             xfer_done,
    input  logic [LEN_W-1:0] xfer_len,
    output logic [31:0]      addr_o,
    output logic [31:0]      count_o,
    output logic [31:0]      upper_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_o  <= '0;
            count_o <= '0;
            upper_o <= '0;
        end else begin
            if (wr.we && wr.idx == IDX_ADDR)
                addr_o <= wr.data;
            else if (xfer_done)
                addr_o <= addr_o + 32'(xfer_len);
            if (wr.we && wr.idx == IDX_COUNT)
                count_o <= wr.data;
            if (wr.we && wr.idx == IDX_UPPER)
                upper_o <= wr.data;
        end
    end

endmodule

// File: rtl/dmacr_swap.sv
module dmacr_swap #(
    parameter int DATA_W = 32
) (
    input  logic              swap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int HALVES = DATA_W / 16;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign dout[h*16 +: 8]     = swap_en ? din[h*16 + 8 +: 8] : din[h*16 +: 8];
        assign dout[h*16 + 8 +: 8] = swap_en ? din[h*16 +: 8]     : din[h*16 + 8 +: 8];
    end

endmodule

// File: rtl/dmacr_chan.sv
module dmacr_chan
    import dmacr_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LEN_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              periph_irq,
    output logic              irq,
    output logic              periph_rst,
    output logic              dir_to_mem,
    input  logic [31:0]       req_addr,
    output logic [31:0]       mem_addr,
    input  logic              swap_en,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [DATA_W-1:0] dev_rd_data,
    input  logic [DATA_W-1:0] dev_wr_data,
    output logic [DATA_W-1:0] mem_wr_data
);

    localparam int IDX_LSB = 2;

    reg_wr_t     wr;
    reg_idx_e    idx;
    logic [31:0] ctrl_w, addr_w, count_w, upper_w;
    logic        unused_addr_bits;

    assign idx              = reg_idx_e'(reg_addr[IDX_LSB +: 2]);
    assign unused_addr_bits = ^{reg_addr[AW-1:IDX_LSB+2], reg_addr[IDX_LSB-1:0]};
    assign wr               = '{we: reg_we, idx: idx, data: reg_wdata};

    dmacr_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .xfer_done    (xfer_done),
        .periph_irq   (periph_irq),
        .ctrl_o       (ctrl_w),
        .irq_o        (irq),
        .periph_rst_o (periph_rst)
    );

    dmacr_addr #(.LEN_W(LEN_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .xfer_done (xfer_done),
        .xfer_len  (xfer_len),
        .addr_o    (addr_w),
        .count_o   (count_w),
        .upper_o   (upper_w)
    );

    dmacr_swap #(.DATA_W(DATA_W)) u_swap_rd (
        .swap_en (swap_en),
        .din     (mem_rd_data),
        .dout    (dev_rd_data)
    );

    dmacr_swap #(.DATA_W(DATA_W)) u_swap_wr (
        .swap_en (swap_en),
        .din     (dev_wr_data),
        .dout    (mem_wr_data)
    );

    always_comb begin
        unique case (idx)
            IDX_CTRL:  reg_rdata = ctrl_w;
            IDX_ADDR:  reg_rdata = addr_w;
            IDX_COUNT: reg_rdata = count_w;
            default:   reg_rdata = upper_w;
        endcase
    end

    assign mem_addr   = req_addr | upper_w;
    assign dir_to_mem = ctrl_w[B_TOMEM];

endmodule

// File: rtl/dmacr_chan_chk.sv
module dmacr_chan_chk #(
    parameter int AW    = 8,
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [AW-1:0]    reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             xfer_done,
    input logic [LEN_W-1:0] xfer_len,
    input logic             irq,
    input logic             periph_rst,
    input logic [31:0]      ctrl_w,
    input logic [31:0]      addr_w
);

    logic ctrl_wr, addr_wr;
    assign ctrl_wr = reg_we && reg_addr[3:2] == 2'd0;
    assign addr_wr = reg_we && reg_addr[3:2] == 2'd1;

    assert_irq_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !reg_wdata[4]) |-> !irq);

    assert_irq_cause_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_w[0] && ctrl_w[4]));

    assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[7]) |=> periph_rst);

    assert_rst_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_wr && reg_wdata[7])) |=> !periph_rst);

    assert_drain_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[6] && !reg_wdata[7]) |=> !ctrl_w[6]);

    assert_loaded_R7: assert property (@(posedge clk) disable iff (rst)
        addr_wr |=> ctrl_w[26]);

    assert_advance_R8: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !addr_wr) |=> (addr_w == $past(addr_w) + 32'($past(xfer_len))));

    assert_pending_R8: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> ctrl_w[0]);

endmodule

bind dmacr_chan dmacr_chan_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .xfer_done  (xfer_done),
    .xfer_len   (xfer_len),
    .irq        (irq),
    .periph_rst (periph_rst),
    .ctrl_w     (ctrl_w),
    .addr_w     (addr_w)
);

// File: tb/tb_dmacr_chan.sv
`timescale 1ns/1ps
module tb_dmacr_chan;

    localparam int AW = 8, LEN_W = 24, DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              xfer_done = 1'b0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic              periph_irq = 1'b0;
    logic              irq, periph_rst, dir_to_mem;
    logic [31:0]       req_addr = '0;
    logic [31:0]       mem_addr;
    logic              swap_en = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0, dev_rd_data, dev_wr_data = '0, mem_wr_data;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dmacr_chan #(.AW(AW), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut (.*);

    // behavioural reference state
    logic [31:0] m_reg [4];
    bit          m_prev, m_rstp;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] swp(input logic [31:0] d, input bit en);
        return en ? {d[23:16], d[31:24], d[7:0], d[15:8]} : d;
    endfunction

    always @(posedge clk) begin
        int  i;
        bit  p;
        logic [31:0] v;
        if (rst) begin
            m_reg[0] = 32'hA000_0000;
            for (int k = 1; k < 4; k++) m_reg[k] = 0;
            m_prev = 0; m_rstp = 0;
        end else begin
            i = int'(reg_addr[3:2]);
            p = m_reg[0][0];
            if (xfer_done || (periph_irq && !m_prev)) p = 1;
            else if (!periph_irq && m_prev) p = 0;
            m_rstp = reg_we && i == 0 && reg_wdata[7];
            if (reg_we && i == 0) begin
                v = reg_wdata;
                if (!v[7] && v[6]) v[6] = 0;
                m_reg[0] = {4'hA, v[27:1], 1'b0};
            end
            m_reg[0][0] = p;
            if (reg_we && i == 1) begin
                m_reg[1] = reg_wdata;
                m_reg[0][26] = 1;
            end else if (xfer_done) m_reg[1] = m_reg[1] + 32'(xfer_len);
            if (reg_we && i == 2) m_reg[2] = reg_wdata;
            if (reg_we && i == 3) m_reg[3] = reg_wdata;
            m_prev = periph_irq;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (model_on && !rst) begin
            check("R2 read data", reg_rdata, m_reg[reg_addr[3:2]]);
            check("R4 irq", {31'b0, irq},
                  {31'b0, m_reg[0][0] & m_reg[0][4] & ~(reg_we && reg_addr[3:2] == 0 && !reg_wdata[4])});
            check("R5 periph_rst", {31'b0, periph_rst}, {31'b0, m_rstp});
            check("R12 dir", {31'b0, dir_to_mem}, {31'b0, m_reg[0][8]});
            check("R10 mem_addr", mem_addr, req_addr | m_reg[3]);
            check("R11 rd swap", dev_rd_data, swp(mem_rd_data, swap_en));
            check("R11 wr swap", mem_wr_data, swp(dev_wr_data, swap_en));
        end
    end

    task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #2;
        reg_we = 0;
    endtask

    task automatic read_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        reg_addr = a; #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #2; end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        model_on = 1;
        // R1 reset values
        read_chk("R1 ctrl reset", 8'h00, 32'hA000_0000);
        read_chk("R1 addr reset", 8'h04, 0);
        read_chk("R1 count reset", 8'h08, 0);
        read_chk("R1 upper reset", 8'h0C, 0);
        // R3, R5: version/pending read-only, reset with drain keeps drain
        reg_write(8'h00, 32'h0FFF_FFFF);
        check("R5 pulse", {31'b0, periph_rst}, 1);
        read_chk("R3 ctrl readback", 8'h00, 32'hAFFF_FFFE);
        idle(1);
        check("R5 single cycle", {31'b0, periph_rst}, 0);
        // R6 drain self-clear
        reg_write(8'h10, 32'h0000_0050);
        read_chk("R6 drain cleared", 8'h00, 32'hA000_0010);
        // R7, R2 unaligned offset
        reg_write(8'h34, 32'h0000_1000);
        read_chk("R7 loaded", 8'h40, 32'hA400_0010);
        read_chk("R2 addr via offset", 8'hF4, 32'h0000_1000);
        // R8 burst report
        @(posedge clk); #2; xfer_done = 1; xfer_len = 24'h20;
        @(posedge clk); #2; xfer_done = 0;
        read_chk("R8 addr advance", 8'h04, 32'h0000_1020);
        check("R8 irq raised", {31'b0, irq}, 1);
        // R8 address write priority
        @(posedge clk); #2; xfer_done = 1; xfer_len = 24'h40;
        reg_we = 1; reg_addr = 8'h04; reg_wdata = 32'h0000_5000;
        @(posedge clk); #2; xfer_done = 0; reg_we = 0;
        read_chk("R8 write wins", 8'h04, 32'h0000_5000);
        // R4 same-cycle drop
        @(posedge clk); #2; reg_we = 1; reg_addr = 8'h00; reg_wdata = 0; #1;
        check("R4 immediate drop", {31'b0, irq}, 0);
        @(posedge clk); #2; reg_we = 0;
        reg_write(8'h00, 32'h10);
        check("R4 pending kept", {31'b0, irq}, 1);
        // R9 edges
        periph_irq = 1; idle(1);
        periph_irq = 0; idle(1);
        check("R9 fall clears", {31'b0, irq}, 0);
        periph_irq = 1; idle(1);
        check("R9 rise sets", {31'b0, irq}, 1);
        periph_irq = 0; xfer_done = 1; xfer_len = 4; idle(1);
        xfer_done = 0;
        check("R9 burst beats fall", {31'b0, irq}, 1);
        // R10 merge, R11 swap
        reg_write(8'h0C, 32'h8000_0000);
        req_addr = 32'h0000_1234; #1;
        check("R10 merged", mem_addr, 32'h8000_1234);
        mem_rd_data = 32'h1122_3344; dev_wr_data = 32'hA1B2_C3D4; swap_en = 1; #1;
        check("R11 swap rd", dev_rd_data, 32'h2211_4433);
        check("R11 swap wr", mem_wr_data, 32'hB2A1_D4C3);
        swap_en = 0; #1;
        check("R11 pass", dev_rd_data, 32'h1122_3344);
        // R12 reads have no effect
        reg_write(8'h08, 32'hDEAD_BEEF);
        for (int k = 0; k < 4; k++) begin
            reg_addr = 8'(k * 4); idle(1);
        end
        read_chk("R12 stable count", 8'h08, 32'hDEAD_BEEF);
        // random phase, compared every cycle
        for (int n = 0; n < 4000; n++) begin
            @(posedge clk); #2;
            reg_we      = ($urandom % 4) == 0;
            reg_addr    = 8'($urandom);
            reg_wdata   = $urandom;
            xfer_done   = ($urandom % 3) == 0;
            xfer_len    = 24'($urandom);
            if (($urandom % 5) == 0) periph_irq = ~periph_irq;
            req_addr    = $urandom;
            swap_en     = 1'($urandom);
            mem_rd_data = $urandom;
            dev_wr_data = $urandom;
        end
        @(posedge clk); #2; reg_we = 0; xfer_done = 0;
        idle(2);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule